// File: doc/BRIEF.md
# Two-Wire Target Register Bank

This block is a target device on a two-wire serial bus (I2C). It holds eight byte-wide registers that a bus controller can fill and read back. The bus lines are oversampled in the system clock domain. SCL is only an input. SDA is open-drain: the block can pull it low or leave it released, and never drives it high. Start and stop conditions are recovered from the synchronized line levels.

A transaction opens with an address byte. The block answers its own 7-bit address and the all-zero general-call address, with either direction bit. In a write, the first data byte loads an internal register pointer. Later bytes all land in the register that pointer names, and the pointer does not move. In a read, the block shifts out the register at the pointer and advances the pointer after each byte. The pointer keeps its value from one transaction to the next.

On the host side the registers appear in parallel on a flat bus. Each register update made from the bus raises a one-cycle strobe together with the index of the register it changed.

Top module: `i2c_reg_bank`

## Requirements
- R1: After reset every register reads 0x00, SDA is released (`sdaPullLow` = 0) and `wrStrobe` is low.
- R2: An address byte whose upper seven bits equal `devAddr` is acknowledged: SDA is pulled low during the ninth SCL clock.
- R3: An address byte that matches neither `devAddr` nor zero gets no acknowledge. All further bytes are ignored (no acknowledge, no register change) until the next start condition.
- R4: In a write, the first data byte sets the pointer. Each later data byte overwrites the register at the pointer, and the pointer stays fixed. Each such write gives one `wrStrobe` pulse with `wrIndex` equal to the pointer.
- R5: Every data byte received after a matching write address is acknowledged. A byte aimed at a pointer of 8 or more is discarded, with no strobe and no register change.
- R6: In a read, the register at the pointer is shifted out MSB first and the pointer then increments. A pointer of 8 or more returns 0x00.
- R7: After each read byte SDA is released for the controller's acknowledge bit. A low bit (ACK) starts the next byte. A high bit (NACK) ends the transfer and leaves SDA released.
- R8: The pointer is kept between transactions, so a read with no pointer write before it continues where the last transfer stopped. Every write addressing makes the next data byte a pointer byte again.
- R9: A start condition (SDA falling while SCL is high) returns the block to the address phase from any state, including mid-transfer. A stop condition (SDA rising while SCL is high) returns it to idle.
- R10: `sdaPullLow` changes level only while SCL is low.
- R11: The general-call byte 0x00 opens a write and the byte 0x01 opens a read, both acknowledged. Both use the same pointer and registers as own-address transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| devAddr | input | 7 | Own 7-bit bus address |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| regData | output | 64 | Register contents, register k at bits 8k+7..8k |
| wrStrobe | output | 1 | One-cycle pulse when the bus updates a register |
| wrIndex | output | 3 | Index of the register updated with the strobe |

## Verification
The assertions assume a legal, slow bus. SCL stays at each level for several system clocks. SDA from the controller changes only while SCL is low, except for intended start and stop conditions. The controller never tries to raise SDA while the target pulls it low. The bench's bus model keeps 10 system clocks in each SCL phase and sets its own SDA at the start of the low phase. It issues repeated starts and stops only from a released line, so the block's edge detection and its rule that SDA moves only while SCL is low are never stressed beyond that envelope.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture sampled SDA into the shifter
    logic shiftOut;  // move the transmit shifter one bit left
    logic loadTx;    // load the shifter from the pointer, then advance pointer
    logic commitRx;  // received byte: load pointer or write register
    logic armPtr;    // next received byte is a pointer byte
  } dpCmd_t;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic busStart,
  output logic busStop
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[LAST-1:0], sclIn};
          sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  assign sclLevel = sclPipe[LAST];
  assign sdaLevel = sdaPipe[LAST];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign busStart = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign busStop  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] devAddr,
  input  logic       sclLevel,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       busStart,
  input  logic       busStop,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       shiftNext,
  output dpCmd_t     cmd,
  output logic       pullLow
);
  busState_t state, nState;
  logic [3:0] bitCnt, nBitCnt;
  logic       readMode, nReadMode;
  logic       nPullLow;
  logic       addrHit;
  logic       byteDone;

  assign addrHit  = (rxByte[7:1] == devAddr) || (rxByte[7:1] == 7'd0);
  assign byteDone = (bitCnt == 4'd8);

  always_comb begin
    nState    = state;
    nBitCnt   = bitCnt;
    nReadMode = readMode;
    nPullLow  = pullLow;
    cmd       = '0;
    if (busStop) begin
      nState   = ST_IDLE;
      nPullLow = 1'b0;
    end else if (busStart) begin
      nState   = ST_ADDR;
      nBitCnt  = 4'd0;
      nPullLow = 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            nBitCnt     = bitCnt + 4'd1;
          end else if (sclFall && byteDone) begin
            nBitCnt = 4'd0;
            if (addrHit) begin
              nPullLow   = 1'b1;
              nReadMode  = rxByte[0];
              cmd.armPtr = ~rxByte[0];
              nState     = ST_ADDR_ACK;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (readMode) begin
              cmd.loadTx = 1'b1;
              nPullLow   = ~txMsb;
              nState     = ST_TX;
            end else begin
              nPullLow = 1'b0;
              nState   = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            nBitCnt     = bitCnt + 4'd1;
          end else if (sclFall && byteDone) begin
            cmd.commitRx = 1'b1;
            nPullLow     = 1'b1;
            nBitCnt      = 4'd0;
            nState       = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            nPullLow = 1'b0;
            nState   = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            nBitCnt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (byteDone) begin
              nPullLow = 1'b0;
              nBitCnt  = 4'd0;
              nState   = ST_TX_ACK;
            end else begin
              cmd.shiftOut = 1'b1;
              nPullLow     = ~shiftNext;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) nState = sdaLevel ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (sclFall) begin
            cmd.loadTx = 1'b1;
            nPullLow   = ~txMsb;
            nState     = ST_TX;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= 4'd0;
      readMode <= 1'b0;
      pullLow  <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nBitCnt;
      readMode <= nReadMode;
      pullLow  <= nPullLow;
    end
  end

  // R9: any start sends the block to the address phase
  assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> (state == ST_ADDR));

  // R9: a stop leaves the block idle with SDA released
  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> (state == ST_IDLE) && !pullLow);

  // R10: the open-drain output moves only while SCL is low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pullLow != $past(pullLow)) |-> !$past(sclLevel));

  // R4: at most one datapath operation per cycle
  assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.shiftIn, cmd.shiftOut, cmd.loadTx, cmd.commitRx}));

endmodule

// File: rtl/i2c_rb_dpath.sv
module i2c_rb_dpath
  import i2c_rb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic                  sdaBit,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic                  shiftNext,
  output logic [NUM_REGS*8-1:0] regData,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex
);
  localparam logic [7:0] PTR_LIMIT = 8'(NUM_REGS);

  logic [7:0] regFile [NUM_REGS];
  logic [7:0] shiftReg;
  logic [7:0] ptr;
  logic       ptrLoaded;
  logic       inRange;
  logic [7:0] readData;
  logic [IDX_W-1:0] ptrIdx;

  assign inRange  = (ptr < PTR_LIMIT);
  assign ptrIdx   = ptr[IDX_W-1:0];
  assign readData = inRange ? regFile[ptrIdx] : 8'h00;

  assign rxByte    = shiftReg;
  assign txMsb     = readData[7];
  assign shiftNext = shiftReg[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= 8'h00;
    end else if (cmd.shiftIn) begin
      shiftReg <= {shiftReg[6:0], sdaBit};
    end else if (cmd.shiftOut) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
    end else if (cmd.loadTx) begin
      shiftReg <= readData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= 8'h00;
      ptrLoaded <= 1'b0;
    end else if (cmd.armPtr) begin
      ptrLoaded <= 1'b0;
    end else if (cmd.commitRx && !ptrLoaded) begin
      ptr       <= shiftReg;
      ptrLoaded <= 1'b1;
    end else if (cmd.loadTx) begin
      ptr <= ptr + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
    end else begin
      wrStrobe <= cmd.commitRx && ptrLoaded && inRange;
      if (cmd.commitRx && ptrLoaded && inRange) wrIndex <= ptrIdx;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regFile[g] <= 8'h00;
        end else if (cmd.commitRx && ptrLoaded && inRange && (ptrIdx == IDX_W'(g))) begin
          regFile[g] <= shiftReg;
        end
      end
      assign regData[g*8 +: 8] = regFile[g];
    end
  endgenerate

  // R4: data bytes never move the pointer
  assert_ptr_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commitRx && ptrLoaded) |=> $stable(ptr));

  // R6: out-of-range reads shift out zero
  assert_rd_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadTx && !inRange) |=> (shiftReg == 8'h00));

  // R8: write addressing makes the next byte a pointer byte
  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.armPtr |=> !ptrLoaded);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rb_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [6:0]            devAddr,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] regData,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex
);
  logic sclLevel, sdaLevel, sclRise, sclFall, busStart, busStop;
  logic [7:0] rxByte;
  logic txMsb, shiftNext;
  dpCmd_t cmd;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .busStart(busStart), .busStop(busStop)
  );

  i2c_rb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .busStart(busStart), .busStop(busStop),
    .rxByte(rxByte), .txMsb(txMsb), .shiftNext(shiftNext),
    .cmd(cmd), .pullLow(sdaPullLow)
  );

  i2c_rb_dpath #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaLevel),
    .rxByte(rxByte), .txMsb(txMsb), .shiftNext(shiftNext),
    .regData(regData), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

endmodule

// File: tb/i2c_reg_bank_test.sv
`timescale 1ns/1ps
module i2c_reg_bank_test;
  localparam int H = 10;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaMaster = 1'b1;
  logic sdaPullLow;
  logic sdaLine;
  logic [63:0] regData;
  logic wrStrobe;
  logic [2:0] wrIndex;

  assign sdaLine = sdaMaster & ~sdaPullLow;

  always #4 clk = ~clk;

  i2c_reg_bank uut (
    .clk(clk), .rstN(rstN), .devAddr(DEV), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .regData(regData), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0] mRegs [8];
  int mPtr = 0;
  bit mLoaded = 0;
  int expStrobes = 0;
  int expIdx = 0;
  bit cmpEn = 0;

  int strobeCnt = 0;
  int lastIdx = -1;
  int pullViolations = 0;
  logic prevPull = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        strobeCnt++;
        lastIdx = int'(wrIndex);
      end
      if (sdaPullLow != prevPull && sclLine) pullViolations++;
      if (cmpEn) begin
        for (int k = 0; k < 8; k++)
          check(regData[k*8 +: 8] == mRegs[k], "R4 register mirror", regData[k*8 +: 8], mRegs[k]);
      end
    end
    prevPull = sdaPullLow;
  end

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaMaster = b;
    waitH(H);
    sclLine = 1'b1;
    waitH(H/2);
    s = sdaLine;
    waitH(H/2);
    sclLine = 1'b0;
  endtask

  task automatic busStart();
    sdaMaster = 1'b1;
    waitH(H);
    sclLine = 1'b1;
    waitH(H);
    sdaMaster = 1'b0;
    waitH(H);
    sclLine = 1'b0;
  endtask

  task automatic busStop();
    sdaMaster = 1'b0;
    waitH(H);
    sclLine = 1'b1;
    waitH(H);
    sdaMaster = 1'b1;
    waitH(H);
  endtask

  task automatic writeRaw(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = !s;
  endtask

  task automatic readRaw(input bit masterAck, output logic [7:0] d);
    logic s;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      d = {d[6:0], s};
    end
    clockBit(masterAck ? 1'b0 : 1'b1, s);
  endtask

  task automatic openXfer(input logic [7:0] a, input bit expAck, input string req);
    bit ack;
    cmpEn = 0;
    busStart();
    writeRaw(a, ack);
    check(ack == expAck, req, ack, expAck);
    if (expAck && !a[0]) mLoaded = 0;
  endtask

  task automatic putData(input logic [7:0] b, input string req);
    bit ack;
    writeRaw(b, ack);
    check(ack == 1'b1, req, ack, 1);
    if (!mLoaded) begin
      mPtr = int'(b);
      mLoaded = 1;
    end else if (mPtr < 8) begin
      mRegs[mPtr] = b;
      expStrobes++;
      expIdx = mPtr;
    end
  endtask

  task automatic getData(input bit masterAck, input string req);
    logic [7:0] d;
    logic [7:0] e;
    readRaw(masterAck, d);
    e = (mPtr < 8) ? mRegs[mPtr] : 8'h00;
    mPtr = (mPtr + 1) % 256;
    check(d == e, req, d, e);
  endtask

  task automatic closeXfer();
    busStop();
    cmpEn = 1;
    waitH(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int k = 0; k < 8; k++) mRegs[k] = 8'h00;
    waitH(5);
    rstN = 1'b1;
    waitH(3);
    // R1 reset state
    check(regData == 64'h0, "R1 registers", int'(regData[31:0]), 0);
    check(sdaPullLow == 1'b0, "R1 sda released", sdaPullLow, 0);
    check(wrStrobe == 1'b0, "R1 strobe low", wrStrobe, 0);
    cmpEn = 1;
    waitH(2);

    // R2 / R4: pointer then two bytes into the same register
    openXfer({DEV, 1'b0}, 1, "R2 own address write ack");
    putData(8'h02, "R5 pointer byte ack");
    putData(8'hA5, "R5 data ack");
    putData(8'h3C, "R5 data ack");
    closeXfer();
    check(strobeCnt == expStrobes, "R4 strobe count", strobeCnt, expStrobes);
    check(lastIdx == expIdx, "R4 strobe index", lastIdx, expIdx);

    // R6 / R7: read with auto increment, ACK then NACK
    openXfer({DEV, 1'b1}, 1, "R2 own address read ack");
    getData(1, "R6 read at pointer");
    getData(0, "R7 second byte after ACK");
    check(sdaPullLow == 1'b0, "R7 released after NACK", sdaPullLow, 0);
    closeXfer();

    // fill registers 4,5,7
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h04, "R5 ack"); putData(8'h77, "R5 ack");
    openXfer({DEV, 1'b0}, 1, "R9 repeated start write ack");
    putData(8'h05, "R8 rearmed pointer"); putData(8'h88, "R5 ack");
    closeXfer();
    check(lastIdx == 5, "R8 pointer reloaded", lastIdx, 5);
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h07, "R5 ack"); putData(8'hE1, "R5 ack");
    closeXfer();

    // R8: pointer-only write, then read across bytes
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h04, "R8 pointer byte");
    closeXfer();
    openXfer({DEV, 1'b1}, 1, "R2 ack");
    getData(1, "R6 reg4"); getData(1, "R6 reg5"); getData(0, "R6 reg6");
    closeXfer();
    // continues at 7 without pointer write, then out of range
    openXfer({DEV, 1'b1}, 1, "R8 read resumes");
    getData(1, "R8 reg7 resume"); getData(0, "R6 out of range zero");
    closeXfer();

    // R5: out-of-range write acknowledged and discarded
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h10, "R5 pointer out of range");
    putData(8'h99, "R5 discarded byte still ack");
    closeXfer();
    check(strobeCnt == expStrobes, "R5 no strobe on discard", strobeCnt, expStrobes);
    openXfer({DEV, 1'b1}, 1, "R2 ack");
    getData(0, "R6 out of range read zero");
    closeXfer();

    // R3: address mismatch
    openXfer(8'h80, 0, "R3 mismatch no ack");
    writeRaw(8'h01, ack);
    check(ack == 1'b0, "R3 later byte ignored", ack, 0);
    writeRaw(8'hFF, ack);
    check(ack == 1'b0, "R3 later byte ignored", ack, 0);
    closeXfer();
    check(strobeCnt == expStrobes, "R3 no write", strobeCnt, expStrobes);

    // R11: general call write and read
    openXfer(8'h00, 1, "R11 general call write ack");
    putData(8'h01, "R11 pointer"); putData(8'h5A, "R11 data");
    closeXfer();
    openXfer(8'h01, 1, "R11 general call read ack");
    getData(0, "R11 general call read data");
    closeXfer();

    // R9: repeated start mid-transfer into read
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h06, "R9 pointer"); putData(8'h11, "R9 data");
    openXfer({DEV, 1'b1}, 1, "R9 repeated start read ack");
    getData(0, "R9 read after repeated start");
    closeXfer();

    // R9: stop after pointer byte, then read from it
    openXfer({DEV, 1'b0}, 1, "R2 ack");
    putData(8'h03, "R9 pointer before stop");
    closeXfer();
    check(sdaPullLow == 1'b0, "R9 idle after stop", sdaPullLow, 0);
    openXfer({DEV, 1'b1}, 1, "R2 ack");
    getData(1, "R9 reg3"); getData(0, "R9 reg4");
    closeXfer();

    check(pullViolations == 0, "R10 pull changes only with SCL low", pullViolations, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule